// File: doc/BRIEF.md
# Nibble-Wide Strobed Register Programming Interface

This block is the write port for a set of sixteen 4-bit control registers. A host drives four shared address/data lines and one strobe line. When the strobe falls, the lines carry a register address. When it rises again, they carry the data for that address. A fast system clock samples the strobe and the lines through two synchronizing flops, and the block detects strobe edges on the synchronized copy.

The registers feed the rest of the chip through an output holding stage. After reset this stage presents fixed start-up values, so the clock path runs from the reference and the load divider is set to divide by four. It keeps those values until a set number of writes (32 by default) has been counted. From then on it passes the register contents straight through. Two register addresses have no storage behind them, which lets a host pad the unlock sequence with dummy writes.

A line-lock helper turns data line 3 into a live phase-detector disable. This happens only when the enable bit is set and the most recently captured address is 15.

Top module: `nibble_prog_port`

## Requirements
- R1: On a falling strobe edge the 4 lines are captured as the address. On the following rising strobe edge the lines are written as data into that register. Register k appears on ctrl_out[4k+3:4k].
- R2: Until unlock, ctrl_out shows the start-up image whatever has been written: register 5 reads 0x1 (divide-by-four code), register 12 reads 0x8 (reference path select), and every other register reads 0x0.
- R3: The write that brings the count to UNLOCK_WRITES (32) raises `unlocked`. That write's own data, and the data of every later write, shows on ctrl_out once the write completes.
- R4: Addresses 13 and 14 hold no storage and always read 0x0 after unlock. Writes to them still advance the write count. Address 10 stores its data like any ordinary register.
- R5: A rising strobe edge with no captured falling edge before it is ignored. This covers a strobe that is already high or still low when reset is released. Such an edge neither writes nor counts.
- R6: The write count saturates at UNLOCK_WRITES. `unlocked` stays high until reset, which clears the count and brings back the start-up image. Stored register contents are not reset.
- R7: pd_disable is high exactly when register 15 bit 3 (as seen on ctrl_out) is 1, the last captured address is 15, and ad_in[3] is high. It follows ad_in[3] combinationally.
- R8: A write completes on the third rising clock edge after the strobe pin rises. The address and data lines must be stable for at least three clock edges before their strobe edge.
- R9: During and right after reset, `unlocked` and `pd_disable` are low and ctrl_out holds the start-up image.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe_in | input | 1 | Asynchronous strobe: falling edge = address, rising edge = data |
| ad_in | input | 4 | Shared address/data lines |
| ctrl_out | output | 64 | Effective register image, register k at bits 4k+3:4k |
| unlocked | output | 1 | High once the unlock write count has been reached |
| pd_disable | output | 1 | Live phase-detector disable |

## Verification
A strobe edge at the pin reaches the design on the second clock edge and is acted on at the third. Each write in the bench therefore holds every line level for four clock cycles. It compares ctrl_out and `unlocked` on the falling clock edge after that hold, which is one cycle after the write has completed. pd_disable is combinational from ad_in[3], so the bench checks it one cycle after it changes the line. Before unlock, every write is checked against the unchanged start-up image. From the 32nd write onward, each write is checked against a bench model of the register contents.

// File: rtl/nprog_pkg.sv
package nprog_pkg;
  localparam int NIB = 4;
  localparam int NREGS = 16;
  localparam int HOLE_A = 13;
  localparam int HOLE_B = 14;
  localparam int LINE_LOCK_ADDR = 15;
  localparam int LINE_LOCK_BIT = 3;

  // Start-up image per register index.
  function automatic logic [NIB-1:0] startup_word(input int idx);
    case (idx)
      5:  return 4'h1;
      12: return 4'h8;
      default: return 4'h0;
    endcase
  endfunction
endpackage

// File: rtl/nprog_sync.sv
module nprog_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      d_sync <= '0;
    end else begin
      meta_q <= d_async;
      d_sync <= meta_q;
    end
  end
endmodule

// File: rtl/nprog_edge_ctl.sv
module nprog_edge_ctl
  import nprog_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           stb_s,
  input  logic [NIB-1:0] ad_s,
  output logic           wr_en,
  output logic [NIB-1:0] wr_addr,
  output logic [NIB-1:0] wr_data,
  output logic [NIB-1:0] last_addr
);
  logic           stb_d_q;
  logic           armed_q, armed_d;
  logic [NIB-1:0] addr_q, addr_d;
  logic           fall_det, rise_det;

  always_comb begin
    fall_det = stb_d_q & ~stb_s;
    rise_det = ~stb_d_q & stb_s;
    wr_en    = rise_det & armed_q;
    armed_d  = armed_q;
    addr_d   = addr_q;
    if (fall_det) begin
      armed_d = 1'b1;
      addr_d  = ad_s;
    end else if (rise_det) begin
      armed_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_d_q <= 1'b0;
      armed_q <= 1'b0;
      addr_q  <= '0;
    end else begin
      stb_d_q <= stb_s;
      armed_q <= armed_d;
      addr_q  <= addr_d;
    end
  end

  assign wr_addr   = addr_q;
  assign wr_data   = ad_s;
  assign last_addr = addr_q;

  // R5: a rise consumes the armed state; nothing writes without a new fall
  a_r5_disarm_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
    rise_det |=> !armed_q);
  // R1: the address follows the lines on a detected fall
  a_r1_addr_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    fall_det |=> (addr_q == $past(ad_s)));
endmodule

// File: rtl/nprog_bank.sv
module nprog_bank
  import nprog_pkg::*;
#(
  parameter int UNLOCK_WRITES = 32,
  localparam int CW = $clog2(UNLOCK_WRITES + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [NIB-1:0]       wr_addr,
  input  logic [NIB-1:0]       wr_data,
  output logic [NREGS*NIB-1:0] ctrl_out,
  output logic                 unlocked
);
  localparam logic [CW-1:0] LIMIT = CW'(UNLOCK_WRITES);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [NREGS*NIB-1:0] store_img;
  logic [NREGS*NIB-1:0] boot_img;

  always_comb begin
    cnt_d = cnt_q;
    if (wr_en && (cnt_q != LIMIT)) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign unlocked = (cnt_q == LIMIT);

  for (genvar gi = 0; gi < NREGS; gi++) begin : g_reg
    assign boot_img[gi*NIB +: NIB] = startup_word(gi);
    if (gi == HOLE_A || gi == HOLE_B) begin : g_hole
      assign store_img[gi*NIB +: NIB] = '0;
    end else begin : g_store
      logic [NIB-1:0] word_q;
      logic           we;
      assign we = wr_en && (wr_addr == NIB'(gi));
      always_ff @(posedge clk) begin
        if (we) word_q <= wr_data;
      end
      assign store_img[gi*NIB +: NIB] = word_q;
    end
  end

  assign ctrl_out = unlocked ? store_img : boot_img;

  a_r6_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT);
  a_r6_unlock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    unlocked |=> unlocked);
  a_r5_count_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cnt_q));
  a_r2_locked_image: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |-> (ctrl_out[5*NIB +: NIB] == 4'h1 && ctrl_out[12*NIB +: NIB] == 4'h8));
  a_r4_holes_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_out[HOLE_A*NIB +: NIB] == '0 && ctrl_out[HOLE_B*NIB +: NIB] == '0);
endmodule

// File: rtl/nibble_prog_port.sv
module nibble_prog_port
  import nprog_pkg::*;
#(
  parameter int UNLOCK_WRITES = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 strobe_in,
  input  logic [3:0]           ad_in,
  output logic [NREGS*NIB-1:0] ctrl_out,
  output logic                 unlocked,
  output logic                 pd_disable
);
  logic [NIB:0]   sync_q;
  logic           wr_en;
  logic [NIB-1:0] wr_addr, wr_data, last_addr;
  logic           ll_enable;

  nprog_sync #(.W(NIB + 1)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_async({strobe_in, ad_in}), .d_sync(sync_q)
  );

  nprog_edge_ctl u_edge (
    .clk(clk), .rst_n(rst_n),
    .stb_s(sync_q[NIB]), .ad_s(sync_q[NIB-1:0]),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .last_addr(last_addr)
  );

  nprog_bank #(.UNLOCK_WRITES(UNLOCK_WRITES)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ctrl_out(ctrl_out), .unlocked(unlocked)
  );

  assign ll_enable  = ctrl_out[LINE_LOCK_ADDR*NIB + LINE_LOCK_BIT];
  assign pd_disable = ll_enable && (last_addr == NIB'(LINE_LOCK_ADDR)) && ad_in[LINE_LOCK_BIT];

  // R7: the disable output is only possible after an address-15 capture
  a_r7_needs_addr15: assert property (@(posedge clk) disable iff (!rst_n)
    pd_disable |-> (last_addr == NIB'(LINE_LOCK_ADDR)));
  // R7: the disable output is only possible with the line-lock enable set
  a_r7_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    pd_disable |-> unlocked);
endmodule

// File: tb/nibble_prog_port_bench.sv
`timescale 1ns/1ps
module nibble_prog_port_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        strobe_in;
  logic [3:0]  ad_in;
  logic [63:0] ctrl_out;
  logic        unlocked;
  logic        pd_disable;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;
  logic [3:0] mdl [16];
  int mcnt = 0;

  always #2.5 clk = ~clk;

  nibble_prog_port u_nibble_prog_port (
    .clk(clk), .rst_n(rst_n), .strobe_in(strobe_in), .ad_in(ad_in),
    .ctrl_out(ctrl_out), .unlocked(unlocked), .pd_disable(pd_disable)
  );

  function automatic logic [63:0] exp_image();
    logic [63:0] img;
    for (int i = 0; i < 16; i++) begin
      if (mcnt < 32) img[i*4 +: 4] = (i == 5) ? 4'h1 : (i == 12) ? 4'h8 : 4'h0;
      else img[i*4 +: 4] = (i == 13 || i == 14) ? 4'h0 : mdl[i];
    end
    return img;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [3:0] d);
    ad_in = a; cycles(4);
    strobe_in = 1'b0; cycles(4);
    ad_in = d; cycles(4);
    strobe_in = 1'b1; cycles(4);
    mdl[a] = d;
    if (mcnt < 32) mcnt++;
  endtask

  task automatic do_reset(input logic stb_level);
    strobe_in = stb_level;
    rst_n = 1'b0; cycles(3);
    rst_n = 1'b1; cycles(4);
    mcnt = 0;
  endtask

  initial begin
    #(200000 * 5.0);
    if (!finished) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [3:0] a, d;
    void'($urandom(32'h1562));
    ad_in = 4'h0;
    // R5/R9: strobe high across reset, so a rise without a fall follows
    strobe_in = 1'b0;
    rst_n = 1'b0;
    cycles(2);
    check("R9 unlocked at reset", {63'b0, unlocked}, 64'h0);
    check("R9 pd_disable at reset", {63'b0, pd_disable}, 64'h0);
    check("R9 image at reset", ctrl_out, exp_image());
    do_reset(1'b1);
    check("R2 image after reset", ctrl_out, exp_image());

    // Fill all addresses; image must stay at start-up (R2, R1)
    for (int i = 0; i < 16; i++) begin
      wr(i[3:0], 4'($urandom));
      check("R2 locked image", ctrl_out, exp_image());
    end
    // Random addresses including dummy 13/14 (R4) up to 31 writes
    for (int i = 0; i < 15; i++) begin
      a = 4'($urandom); d = 4'($urandom);
      wr(a, d);
      check("R2 locked image", ctrl_out, exp_image());
    end
    check("R5 not yet unlocked at 31 writes", {63'b0, unlocked}, 64'h0);
    wr(4'd13, 4'hF);
    check("R3 unlocked at 32nd write", {63'b0, unlocked}, 64'h1);
    check("R3 R4 image after unlock", ctrl_out, exp_image());

    // Random writes after unlock (R1, R3, R4, R6)
    for (int i = 0; i < 30; i++) begin
      a = 4'($urandom); d = 4'($urandom);
      wr(a, d);
      check("R1 R3 live write", ctrl_out, exp_image());
    end
    wr(4'd14, 4'h7);
    check("R4 address 14 reads zero", {60'b0, ctrl_out[59:56]}, 64'h0);
    wr(4'd10, 4'hA);
    check("R4 address 10 stores", {60'b0, ctrl_out[43:40]}, 64'hA);
    check("R6 unlocked stays", {63'b0, unlocked}, 64'h1);

    // R8: write completes on the third clock edge after the pin rises
    ad_in = 4'd3; cycles(4);
    strobe_in = 1'b0; cycles(4);
    ad_in = 4'h6; cycles(4);
    strobe_in = 1'b1; cycles(2);
    check("R8 not yet written after 2 edges", {60'b0, ctrl_out[15:12]}, {60'b0, mdl[3]});
    cycles(1);
    mdl[3] = 4'h6;
    check("R8 written after 3 edges", {60'b0, ctrl_out[15:12]}, 64'h6);
    cycles(1);

    // R7 line-lock disable
    wr(4'd15, 4'h8);
    ad_in = 4'h8; cycles(1);
    check("R7 disable high", {63'b0, pd_disable}, 64'h1);
    ad_in = 4'h0; cycles(1);
    check("R7 follows line 3 low", {63'b0, pd_disable}, 64'h0);
    wr(4'd3, 4'h1);
    ad_in = 4'h8; cycles(1);
    check("R7 other address blocks", {63'b0, pd_disable}, 64'h0);
    wr(4'd15, 4'h0);
    ad_in = 4'h8; cycles(1);
    check("R7 enable clear blocks", {63'b0, pd_disable}, 64'h0);

    // R6/R5: reset in mid write with strobe low, then a lone rise is ignored
    ad_in = 4'd2; cycles(4);
    strobe_in = 1'b0; cycles(4);
    do_reset(1'b0);
    check("R6 relocked after reset", {63'b0, unlocked}, 64'h0);
    check("R6 start-up image after reset", ctrl_out, exp_image());
    ad_in = 4'h5; cycles(4);
    strobe_in = 1'b1; cycles(4);
    for (int i = 0; i < 31; i++) wr(4'd13, 4'h0);
    check("R5 lone rise not counted", {63'b0, unlocked}, 64'h0);
    wr(4'd13, 4'h0);
    check("R3 unlocked again", {63'b0, unlocked}, 64'h1);
    check("R5 lone rise did not write", {60'b0, ctrl_out[11:8]}, {60'b0, mdl[2]});

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule